// File: doc/BRIEF.md
# Framed SPI Slave Shift Engine

This block is a 16-bit serial shift engine that takes its bit clock from an external master and moves words in framed transfers. The serial clock runs without pause, so a frame sync pulse marks the start of each word. The `fs_dir` input selects which side produces that pulse. With `fs_dir` low, the block drives the frame sync pin itself: a write to the transmit register requests a word, and the block emits a one-period pulse together with the first bit. With `fs_dir` high, the master drives the pin and the block starts a word once it sees the pulse.

Software-side access runs on the system clock `clk`. The block passes the serial clock, serial data and the frame sync input through a two-stage synchronizer and finds serial clock edges in the `clk` domain. By default, data leaves on the falling serial clock edge (transmit edge) and is captured on the rising edge (sample edge). The `SCK_INV` parameter swaps the two edges. By default the frame sync is active-high, and `FS_INV` inverts it for both directions.

Top module: `frm_spi_slave`

## Requirements
- R1: `fs_oe` is 1 when `fs_dir` is 0, so the pin is an output. `fs_oe` is 0 when `fs_dir` is 1, so the pin is an input. While `fs_dir` is 1, `fs_out` stays at its inactive level (0).
- R2: With `fs_dir`=0, a `tx_wr` pulse while idle makes `fs_out` go active (1) at the next falling serial clock edge. It stays active for exactly one serial clock period and drops at the following falling edge.
- R3: A word is sent MSB first, one bit per falling serial clock edge. Bit 15 appears on `sdo` at the same falling edge that starts the word.
- R4: With `fs_dir`=1, a `tx_wr` alone starts nothing. `fs_in` is sampled on rising serial clock edges. Once it is sampled at 1 while idle, the next falling edge starts a word carrying the last written transmit value.
- R5: `sdi` is captured on rising serial clock edges, MSB first. After the 16th rising edge of a word, `rx_data` holds the captured word and `rx_valid` is 1. A one-cycle `rx_rd` pulse clears `rx_valid`.
- R6: Whenever no word is in progress, `sdo` is 0 after each falling serial clock edge.
- R7: With `fs_dir`=1, an active `fs_in` sampled during a word is ignored, with one exception. If it is sampled on the word's 16th rising edge, the next word starts at the very next falling edge, with no idle period in between.
- R8: With `fs_dir`=0, a `tx_wr` during a word is held. The pulse and the new word start at the first falling edge after the current word completes, with no idle period in between.
- R9: After reset, `sdo`=0, `fs_out`=0, `rx_valid`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_dir | input | 1 | 0: block drives frame sync, 1: master drives frame sync |
| sck_in | input | 1 | Free-running serial clock from the master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| fs_in | input | 1 | Frame sync pin, input path |
| fs_out | output | 1 | Frame sync pin, output path |
| fs_oe | output | 1 | Output enable for the frame sync pin |
| tx_data | input | 16 | Transmit word |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | A received word is waiting |
| rx_rd | input | 1 | Read strobe, clears `rx_valid` |

## Verification
Every serial clock edge reaches the outputs three system clock edges after the pin changes: two synchronizer stages, then the register that the detected edge updates. `sdo`, `fs_out`, `rx_data` and `rx_valid` therefore settle well within a quarter of the bench's serial clock period. The bench holds each serial clock level for eight system cycles. It reads `sdo` and `fs_out` at the end of the low phase, just before it raises the clock, and reads the receive outputs eight cycles after the 16th rising edge. Back-to-back cases are judged by the period in which bit 15 and the pulse appear, counted in serial clock periods from the write or the sampled frame sync.

// File: rtl/frm_spi_slave.sv
module frm_spi_slave #(
  parameter int WORD_W = 16,
  parameter int SYNC_N = 2,
  parameter int SCK_INV = 0,
  parameter int FS_INV = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_dir,
  input  logic              sck_in,
  input  logic              sdi,
  output logic              sdo,
  input  logic              fs_in,
  output logic              fs_out,
  output logic              fs_oe,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_rd
);
  localparam int CW = $clog2(WORD_W);
  localparam logic SCKI = (SCK_INV != 0);
  localparam logic FSI = (FS_INV != 0);

  logic [SYNC_N-1:0] sck_sy, sdi_sy, fs_sy;
  logic sck_d;
  logic [WORD_W-1:0] hold, tx_sh;
  logic [WORD_W-2:0] rx_sh;
  logic [CW-1:0] bitcnt;
  logic pend, armed, active, fs_pulse, sdo_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0; sdi_sy <= '0; fs_sy <= '0; sck_d <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_N-2:0], sck_in};
      sdi_sy <= {sdi_sy[SYNC_N-2:0], sdi};
      fs_sy  <= {fs_sy[SYNC_N-2:0], fs_in};
      sck_d  <= sck_sy[SYNC_N-1];
    end

  wire sck_e  = sck_sy[SYNC_N-1] ^ SCKI;
  wire sckd_e = sck_d ^ SCKI;
  wire samp_edge = sck_e & ~sckd_e;
  wire tx_edge   = ~sck_e & sckd_e;
  wire sdi_s     = sdi_sy[SYNC_N-1];
  wire fs_seen   = fs_sy[SYNC_N-1] ^ FSI;
  wire last_samp = samp_edge && active && (bitcnt == CW'(WORD_W-1));
  wire start     = tx_edge && !active && (fs_dir ? armed : pend);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; pend <= 1'b0;
    end else if (tx_wr) begin
      hold <= tx_data; pend <= ~fs_dir;
    end else if (start || fs_dir) pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else if (!fs_dir || start) armed <= 1'b0;
    else if (samp_edge && fs_seen && (!active || last_samp)) armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; fs_pulse <= 1'b0; sdo_r <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; bitcnt <= '0;
      rx_data <= '0; rx_valid <= 1'b0;
    end else begin
      if (rx_rd) rx_valid <= 1'b0;
      if (tx_edge) begin
        fs_pulse <= 1'b0;
        if (start) begin
          active <= 1'b1;
          bitcnt <= '0;
          sdo_r <= hold[WORD_W-1];
          tx_sh <= {hold[WORD_W-2:0], 1'b0};
          fs_pulse <= ~fs_dir;
        end else if (active) begin
          sdo_r <= tx_sh[WORD_W-1];
          tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end else sdo_r <= 1'b0;
      end
      if (samp_edge && active) begin
        rx_sh <= {rx_sh[WORD_W-3:0], sdi_s};
        bitcnt <= bitcnt + 1'b1;
        if (last_samp) begin
          active <= 1'b0;
          bitcnt <= '0;
          rx_data <= {rx_sh, sdi_s};
          rx_valid <= 1'b1;
        end
      end
    end

  assign sdo = sdo_r;
  assign fs_out = fs_pulse ^ FSI;
  assign fs_oe = ~fs_dir;

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> bitcnt == '0); // R5
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(samp_edge)); // R5
  AST_PULSE_RISE_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_pulse) |-> $past(tx_edge) && !$past(fs_dir)); // R2
  AST_PULSE_FALL_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_pulse) |-> $past(tx_edge)); // R2
  AST_WORD_START_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(tx_edge)); // R3
  AST_IDLE_SDO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_edge) && !active) |-> !sdo); // R6
endmodule

// File: tb/sim_frm_spi_slave.sv
module sim_frm_spi_slave;
  logic clk = 1'b0, rst_n = 1'b0, fs_dir = 1'b0, sck_in = 1'b1, sdi = 1'b0, fs_in = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [15:0] tx_data = '0;
  logic sdo, fs_out, fs_oe, rx_valid;
  logic [15:0] rx_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  frm_spi_slave u0 (.clk(clk), .rst_n(rst_n), .fs_dir(fs_dir), .sck_in(sck_in), .sdi(sdi),
    .sdo(sdo), .fs_in(fs_in), .fs_out(fs_out), .fs_oe(fs_oe), .tx_data(tx_data),
    .tx_wr(tx_wr), .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd));

  localparam logic [31:0] VEC [4] = '{
    {16'hA5C3, 16'h3C5A}, {16'hFFFF, 16'h0000},
    {16'h0001, 16'h8000}, {16'h1234, 16'hFEDC}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic per(input logic fsv, input logic dv, output logic so, output logic fo);
    @(negedge clk); sck_in = 1'b0; sdi = dv; fs_in = fsv;
    repeat (8) @(negedge clk);
    so = sdo; fo = fs_out; sck_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] m, input int fs_at, input int wr_at, input logic [15:0] wv,
                      output logic [15:0] got, output logic [15:0] fsm);
    for (int i = 0; i < 16; i++) begin
      logic so, fo;
      per(fs_at == i, m[15-i], so, fo);
      got[15-i] = so; fsm[15-i] = fo;
      if (wr_at == i) wr(wv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] got, fsm;
    logic so, fo;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sdo == 1'b0, "R9 sdo", sdo, 0);
    chk(fs_out == 1'b0, "R9 fs_out", fs_out, 0);
    chk(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    chk(rx_data == 16'h0, "R9 rx_data", rx_data, 0);
    chk(fs_oe == 1'b1, "R1 oe out", fs_oe, 1);

    for (int v = 0; v < 4; v++) begin
      wr(VEC[v][31:16]);
      xfer(VEC[v][15:0], -1, -1, 16'h0, got, fsm);
      chk(got == VEC[v][31:16], "R3 tx word", got, VEC[v][31:16]);
      chk(fsm == 16'h8000, "R2 sync pulse", fsm, 16'h8000);
      chk(rx_data == VEC[v][15:0], "R5 rx word", rx_data, VEC[v][15:0]);
      chk(rx_valid == 1'b1, "R5 valid set", rx_valid, 1);
      rd();
      chk(rx_valid == 1'b0, "R5 valid clr", rx_valid, 0);
      per(1'b0, 1'b0, so, fo);
      chk(so == 1'b0, "R6 idle sdo", so, 0);
      chk(fo == 1'b0, "R2 no pulse idle", fo, 0);
    end

    // R8: write during a word, next word back-to-back
    wr(16'h8181);
    xfer(16'h1111, -1, 3, 16'hC3E7, got, fsm);
    chk(got == 16'h8181, "R8 first word", got, 16'h8181);
    xfer(16'h2222, -1, -1, 16'h0, got, fsm);
    chk(got == 16'hC3E7, "R8 second word", got, 16'hC3E7);
    chk(fsm == 16'h8000, "R8 second pulse", fsm, 16'h8000);
    chk(rx_data == 16'h2222, "R8 rx second", rx_data, 16'h2222);
    per(1'b0, 1'b0, so, fo);
    chk(so == 1'b0, "R6 idle after R8", so, 0);

    // sync-input mode
    @(negedge clk); fs_dir = 1'b1;
    @(negedge clk);
    chk(fs_oe == 1'b0, "R1 oe in", fs_oe, 0);
    wr(16'hC0DE);
    per(1'b0, 1'b0, so, fo);
    chk(so == 1'b0, "R4 write alone idle", so, 0);
    per(1'b1, 1'b0, so, fo);
    chk(so == 1'b0, "R4 sync period idle", so, 0);
    xfer(16'h6B29, -1, -1, 16'h0, got, fsm);
    chk(got == 16'hC0DE, "R4 tx word", got, 16'hC0DE);
    chk(fsm == 16'h0000, "R1 fs_out inactive", fsm, 0);
    chk(rx_data == 16'h6B29, "R5 rx in-mode", rx_data, 16'h6B29);

    // R7: sync mid-word ignored
    wr(16'hA5A5);
    per(1'b1, 1'b0, so, fo);
    xfer(16'h0F0F, 6, -1, 16'h0, got, fsm);
    chk(got == 16'hA5A5, "R7 word intact", got, 16'hA5A5);
    per(1'b0, 1'b0, so, fo);
    chk(so == 1'b0, "R7 no extra word", so, 0);
    per(1'b0, 1'b0, so, fo);
    chk(so == 1'b0, "R7 still idle", so, 0);

    // R7: sync on last sample edge, back-to-back
    wr(16'h9F01);
    per(1'b1, 1'b0, so, fo);
    xfer(16'h4455, 15, -1, 16'h0, got, fsm);
    chk(got == 16'h9F01, "R7 b2b first", got, 16'h9F01);
    chk(rx_data == 16'h4455, "R7 rx first", rx_data, 16'h4455);
    xfer(16'hBEEF, -1, -1, 16'h0, got, fsm);
    chk(got == 16'h9F01, "R7 b2b second", got, 16'h9F01);
    chk(rx_data == 16'hBEEF, "R7 rx second", rx_data, 16'hBEEF);
    per(1'b0, 1'b0, so, fo);
    chk(so == 1'b0, "R6 idle end", so, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule